// File: doc/BRIEF.md
# Programmable IDE PIO Cycle Timer

This block produces the pin-level waveform of a single programmed-I/O access to an IDE storage device. After a start request, the access runs through three phases. The address phase puts the register select on the chip-select and address lines. The strobe phase asserts the read or write strobe. The recovery phase releases the strobe and holds the address. A one-cycle completion pulse follows. The length of each phase is counted in clock cycles from a 16-bit timing word, which the host writes and can read back.

The same timing word also carries static controls. A powerdown bit forces every bus output low and raises the card power output. A software reset bit pulls the device reset line low. A cable-select bit sets the cable-select level. IORDY flow control is not used, so the strobe length depends only on the programmed field. For a read, the data bus is sampled on the last clock of the strobe and returned with the completion pulse. For a write, the data bus is driven for the whole access. The chip selects, address lines and strobes are shown as active-high levels, where 1 means asserted.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000_9FFF. Powerdown is set and every timing field holds its maximum value.
- R2: `cfg_rdata[31:16]` always reads zero. Values written to bits 31:16 are ignored. Bits 15:0 read back exactly what was written.
- R3: The timing word has these fields: bits 2:0 = setup count S, bits 7:3 = pulse count P, bits 12:8 = recovery count R, bit 13 = cable select, bit 14 = software reset, bit 15 = powerdown. The address stays valid without a strobe for S+1 cycles before the strobe asserts.
- R4: The strobe stays asserted for P+2 cycles. It is `ide_rd_strb` when `is_write`=0 and `ide_wr_strb` when `is_write`=1. The two strobes are never high together.
- R5: After the strobe falls, recovery lasts R+2 cycles. In the next cycle, `done` is high for exactly one cycle, and the bus lines have returned to idle.
- R6: For a read, `rd_data` holds the value of `ide_dd_in` from the last strobe cycle, starting with the `done` cycle.
- R7: For a write, `ide_dd_oe` is 1 and `ide_dd_out` equals `wr_data` from the first setup cycle to the last recovery cycle. At all other times, `ide_dd_oe` is 0.
- R8: During an access, `ide_cs` = `reg_sel[4:3]` and `ide_addr` = `reg_sel[2:0]`, latched at start and held steady. When idle, both are zero.
- R9: While powerdown is set, the following outputs are all 0: `ide_cs`, `ide_addr`, both strobes, `ide_dd_oe` and `ide_rst_n`. `card_pwr` is 1.
- R10: With powerdown clear, software reset = 1 drives `ide_rst_n` to 0, and `ide_rst_n` is 1 otherwise. `ide_csel` follows the cable-select bit, and `card_pwr` is 0.
- R11: A start during powerdown gives `done` on the next cycle, sets `rd_data` to zero, and produces no strobe.
- R12: The phase lengths are fixed when a start is accepted. A timing-word write during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Timing word write value |
| cfg_rdata | output | 32 | Timing word readback |
| start | input | 1 | Start one access (taken when idle) |
| is_write | input | 1 | 1 = write access, 0 = read access |
| reg_sel | input | 5 | Chip selects [4:3] and address [2:0] |
| wr_data | input | 16 | Data for a write access |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| ide_cs | output | 2 | Chip select levels |
| ide_addr | output | 3 | Device register address |
| ide_rd_strb | output | 1 | Read strobe, active high |
| ide_wr_strb | output | 1 | Write strobe, active high |
| ide_dd_out | output | 16 | Data bus drive value |
| ide_dd_oe | output | 1 | Data bus output enable |
| ide_dd_in | input | 16 | Data bus sampled value |
| ide_rst_n | output | 1 | Device reset, active low |
| ide_csel | output | 1 | Cable select level |
| card_pwr | output | 1 | Card power control, high in powerdown |

## Verification
The bench builds the block with its default field widths: 3 bits for setup and 5 bits each for pulse and recovery. This makes both the shortest timing (all fields zero) and the longest (7, 31, 31) reachable, so the counters are tested at their wrap limits. Timing words for a slow legacy mode and for the fast 120 ns mode are also run. During every access, the bench counts cycles of address-only, strobe and recovery time, and it changes the data bus input on every cycle. A wrong capture cycle therefore shows up as a wrong `rd_data` value.

// File: rtl/ide_pio_pkg.sv
// Shared definitions for the IDE PIO timer: phase encoding, timing-word
// layout and its reset value. Assumes a 16-bit stored timing word.
package ide_pio_pkg;
    localparam int SETUP_W  = 3;
    localparam int PULSE_W  = 5;
    localparam int RECOV_W  = 5;
    localparam int CFG_W    = 16;
    localparam logic [31:0] CFG_RESET = 32'h0000_9FFF;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_RECOV = 2'd3
    } phase_t;

    // Field order matches bit positions 15 down to 0 of the timing word.
    typedef struct packed {
        logic               pdn;
        logic               srst;
        logic               csel;
        logic [RECOV_W-1:0] recov;
        logic [PULSE_W-1:0] pulse;
        logic [SETUP_W-1:0] setup;
    } pio_cfg_t;
endpackage

// File: rtl/ide_cfg_reg.sv
// Timing/control word storage. Holds bits 15:0 of the host-written word
// and returns zero in the unused upper half. Assumes one write per cycle.
module ide_cfg_reg
    import ide_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output pio_cfg_t    cfg,
    output logic [31:0] rdata
);
    pio_cfg_t cfg_q;
    logic     unused_hi;

    assign unused_hi = ^wdata[31:CFG_W];

    // Load the stored word on a host write; reset to the powerdown default.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= pio_cfg_t'(CFG_RESET[CFG_W-1:0]);
        else if (we) cfg_q <= pio_cfg_t'(wdata[CFG_W-1:0]);
    end

    assign cfg   = cfg_q;
    assign rdata = {{(32-CFG_W){1'b0}}, cfg_q};

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata == {16'h0, $past(wdata[15:0])});
endmodule

// File: rtl/ide_phase_seq.sv
// Phase sequencer: walks setup -> pulse -> recovery using one down-counter.
// Snapshots pulse and recovery lengths at start. Assumes start is held
// low while busy (a start outside idle is ignored).
module ide_phase_seq
    import ide_pio_pkg::*;
#(
    parameter int S_W = SETUP_W,
    parameter int P_W = PULSE_W,
    parameter int R_W = RECOV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           pdn,
    input  logic [S_W-1:0] setup_len,
    input  logic [P_W-1:0] pulse_len,
    input  logic [R_W-1:0] recov_len,
    output phase_t         phase,
    output logic           accept,
    output logic           pdn_ack,
    output logic           sample_en,
    output logic           done
);
    localparam int MAX_W = (P_W > R_W) ? P_W : R_W;
    localparam int CNT_W = ((S_W > MAX_W) ? S_W : MAX_W) + 1;

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [P_W-1:0]   pulse_q;
    logic [R_W-1:0]   recov_q;
    logic             done_q;
    logic             last;

    assign last      = (cnt_q == '0);
    assign accept    = (phase_q == PH_IDLE) && start && !pdn;
    assign pdn_ack   = (phase_q == PH_IDLE) && start && pdn;
    assign sample_en = (phase_q == PH_PULSE) && last;
    assign phase     = phase_q;
    assign done      = done_q;

    // Advance phases and count down the remaining cycles of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pulse_q <= '0;
            recov_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (pdn_ack) done_q <= 1'b1;
                    if (accept) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(setup_len);
                        pulse_q <= pulse_len;
                        recov_q <= recov_len;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= CNT_W'(pulse_q) + CNT_W'(1);
                    end else cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_PULSE: begin
                    if (last) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= CNT_W'(recov_q) + CNT_W'(1);
                    end else cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_RECOV: begin
                    if (last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else cnt_q <= cnt_q - CNT_W'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    pdn_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_ack |=> (done && phase == PH_IDLE));
    // R3
    pulse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && $past(phase) != PH_PULSE) |-> $past(phase) == PH_SETUP);
endmodule

// File: rtl/ide_pin_drive.sv
// Pin driver: latches the access request, shapes chip selects, address,
// strobes and data bus from the current phase, applies powerdown forcing
// and static controls, and captures read data. Strobes are active high.
module ide_pin_drive
    import ide_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CS_W   = 2,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  phase_t                 phase,
    input  logic                   accept,
    input  logic                   pdn_ack,
    input  logic                   sample_en,
    input  logic                   pdn,
    input  logic                   srst,
    input  logic                   csel,
    input  logic                   is_write,
    input  logic [CS_W+ADDR_W-1:0] reg_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [DATA_W-1:0]      dd_in,
    output logic [DATA_W-1:0]      rd_data,
    output logic [CS_W-1:0]        cs,
    output logic [ADDR_W-1:0]      addr,
    output logic                   rd_strb,
    output logic                   wr_strb,
    output logic [DATA_W-1:0]      dd_out,
    output logic                   dd_oe,
    output logic                   dev_rst_n,
    output logic                   csel_o,
    output logic                   card_pwr
);
    logic                   wr_q;
    logic [CS_W+ADDR_W-1:0] sel_q;
    logic [DATA_W-1:0]      wdat_q;
    logic [DATA_W-1:0]      rd_q;
    logic                   live;

    // Latch direction, register select and write data when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            sel_q  <= '0;
            wdat_q <= '0;
        end else if (accept) begin
            wr_q   <= is_write;
            sel_q  <= reg_sel;
            wdat_q <= wr_data;
        end
    end

    // Capture bus data on the last strobe cycle; clear on a powerdown start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_q <= '0;
        else if (pdn_ack)           rd_q <= '0;
        else if (sample_en && !wr_q) rd_q <= dd_in;
    end

    assign live      = (phase != PH_IDLE) && !pdn;
    assign cs        = live ? sel_q[CS_W+ADDR_W-1:ADDR_W] : '0;
    assign addr      = live ? sel_q[ADDR_W-1:0] : '0;
    assign rd_strb   = live && (phase == PH_PULSE) && !wr_q;
    assign wr_strb   = live && (phase == PH_PULSE) && wr_q;
    assign dd_oe     = live && wr_q;
    assign dd_out    = wdat_q;
    assign dev_rst_n = !(pdn || srst);
    assign csel_o    = csel;
    assign card_pwr  = pdn;
    assign rd_data   = rd_q;

    // R4
    strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strb && wr_strb));
    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE && !pdn && !$past(pdn))
            |-> ($stable(cs) && $stable(addr)));
    // R7
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe |-> !rd_strb);
endmodule

// File: rtl/ide_pio_timer.sv
// Top of the IDE PIO cycle timer: timing word, phase sequencer and pin
// driver. Assumes a single clock domain and synchronous active-low reset.
module ide_pio_timer
    import ide_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CS_W   = 2,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic                   start,
    input  logic                   is_write,
    input  logic [CS_W+ADDR_W-1:0] reg_sel,
    input  logic [DATA_W-1:0]      wr_data,
    output logic                   done,
    output logic [DATA_W-1:0]      rd_data,
    output logic [CS_W-1:0]        ide_cs,
    output logic [ADDR_W-1:0]      ide_addr,
    output logic                   ide_rd_strb,
    output logic                   ide_wr_strb,
    output logic [DATA_W-1:0]      ide_dd_out,
    output logic                   ide_dd_oe,
    input  logic [DATA_W-1:0]      ide_dd_in,
    output logic                   ide_rst_n,
    output logic                   ide_csel,
    output logic                   card_pwr
);
    pio_cfg_t cfg;
    phase_t   phase;
    logic     accept, pdn_ack, sample_en;

    ide_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    ide_phase_seq #(.S_W(SETUP_W), .P_W(PULSE_W), .R_W(RECOV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pdn(cfg.pdn),
        .setup_len(cfg.setup), .pulse_len(cfg.pulse), .recov_len(cfg.recov),
        .phase(phase), .accept(accept), .pdn_ack(pdn_ack),
        .sample_en(sample_en), .done(done)
    );

    ide_pin_drive #(.DATA_W(DATA_W), .CS_W(CS_W), .ADDR_W(ADDR_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .phase(phase), .accept(accept),
        .pdn_ack(pdn_ack), .sample_en(sample_en), .pdn(cfg.pdn),
        .srst(cfg.srst), .csel(cfg.csel), .is_write(is_write),
        .reg_sel(reg_sel), .wr_data(wr_data), .dd_in(ide_dd_in),
        .rd_data(rd_data), .cs(ide_cs), .addr(ide_addr),
        .rd_strb(ide_rd_strb), .wr_strb(ide_wr_strb), .dd_out(ide_dd_out),
        .dd_oe(ide_dd_oe), .dev_rst_n(ide_rst_n), .csel_o(ide_csel),
        .card_pwr(card_pwr)
    );

    // R9
    pdn_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15] && $past(cfg_rdata[15])) |->
            (ide_cs == '0 && ide_addr == '0 && !ide_rd_strb && !ide_wr_strb
             && !ide_dd_oe && !ide_rst_n && card_pwr));
endmodule

// File: tb/ide_pio_timer_test.sv
module ide_pio_timer_test;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [15:0] wr_data = '0;
    logic        done;
    logic [15:0] rd_data;
    logic [1:0]  ide_cs;
    logic [2:0]  ide_addr;
    logic        ide_rd_strb, ide_wr_strb;
    logic [15:0] ide_dd_out;
    logic        ide_dd_oe;
    logic [15:0] ide_dd_in = '0;
    logic        ide_rst_n, ide_csel, card_pwr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_pio_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .start(start), .is_write(is_write),
        .reg_sel(reg_sel), .wr_data(wr_data), .done(done), .rd_data(rd_data),
        .ide_cs(ide_cs), .ide_addr(ide_addr), .ide_rd_strb(ide_rd_strb),
        .ide_wr_strb(ide_wr_strb), .ide_dd_out(ide_dd_out),
        .ide_dd_oe(ide_dd_oe), .ide_dd_in(ide_dd_in), .ide_rst_n(ide_rst_n),
        .ide_csel(ide_csel), .card_pwr(card_pwr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit pdn, input bit srst, input bit csel,
                                           input int s, input int p, input int r);
        return {16'h0, pdn, srst, csel, r[4:0], p[4:0], s[2:0]};
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R1, R9: state straight after reset
    task automatic t_reset();
        @(negedge clk);
        chk(cfg_rdata == 32'h0000_9FFF, "R1 reset word", cfg_rdata, 32'h9FFF);
        chk(ide_cs == 0 && ide_addr == 0 && !ide_rd_strb && !ide_wr_strb && !ide_dd_oe,
            "R9 bus low in powerdown", {ide_cs, ide_addr, ide_rd_strb, ide_wr_strb, ide_dd_oe}, 0);
        chk(!ide_rst_n && card_pwr, "R9 reset low power high", {ide_rst_n, card_pwr}, 1);
        chk(!done && rd_data == 0, "R1 idle outputs", {done, rd_data}, 0);
    endtask

    // R2: upper half ignored, lower half read back
    task automatic t_cfg_readback();
        write_cfg(32'hA5C3_1234);
        chk(cfg_rdata == 32'h0000_1234, "R2 readback", cfg_rdata, 32'h1234);
    endtask

    // R10: soft reset and cable select without powerdown
    task automatic t_static();
        write_cfg(mk_cfg(0, 1, 1, 0, 0, 0));
        chk(!ide_rst_n && ide_csel && !card_pwr, "R10 srst+csel", {ide_rst_n, ide_csel, card_pwr}, 3'b010);
        write_cfg(mk_cfg(0, 0, 0, 0, 0, 0));
        chk(ide_rst_n && !ide_csel && !card_pwr, "R10 released", {ide_rst_n, ide_csel, card_pwr}, 3'b100);
    endtask

    // R3..R8, R12: one full access with per-cycle phase counting
    task automatic run_access(input bit wr, input logic [4:0] sel, input logic [15:0] wd,
                              input int s, input int p, input int r,
                              input bit mid_write, input string tag);
        int n_set = 0, n_pul = 0, n_rec = 0;
        bit sel_ok = 1, oe_ok = 1, other_ok = 1;
        logic [15:0] last_in = '0;
        write_cfg(mk_cfg(0, 0, 0, s, p, r));
        @(negedge clk);
        start = 1'b1; is_write = wr; reg_sel = sel; wr_data = wd;
        @(negedge clk);
        start = 1'b0; is_write = ~wr; reg_sel = ~sel; wr_data = ~wd;
        for (int k = 0; k < 200; k++) begin
            ide_dd_in = 16'hB000 + 16'(k * 7);
            if (mid_write && k == 0) begin cfg_we = 1'b1; cfg_wdata = mk_cfg(0, 0, 0, 7, 31, 31); end
            if (mid_write && k == 1) cfg_we = 1'b0;
            #1;
            if (done) break;
            if ({ide_cs, ide_addr} != sel) sel_ok = 0;
            if (ide_dd_oe != wr || (wr && ide_dd_out != wd)) oe_ok = 0;
            if (wr ? ide_rd_strb : ide_wr_strb) other_ok = 0;
            if (wr ? ide_wr_strb : ide_rd_strb) begin n_pul++; last_in = ide_dd_in; end
            else if (n_pul == 0) n_set++;
            else n_rec++;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk(done, {"R5 done seen ", tag}, done, 1);
        chk(n_set == s + 1, {"R3 setup cycles ", tag}, n_set, s + 1);
        chk(n_pul == p + 2, {"R4 pulse cycles ", tag}, n_pul, p + 2);
        chk(other_ok, {"R4 wrong strobe ", tag}, 0, 1);
        chk(n_rec == r + 2, {"R5 recovery cycles ", tag}, n_rec, r + 2);
        chk(sel_ok, {"R8 select held ", tag}, 0, 1);
        chk(oe_ok, {"R7 data drive ", tag}, 0, 1);
        if (!wr) chk(rd_data == last_in, {"R6 read capture ", tag}, rd_data, last_in);
        chk(ide_cs == 0 && ide_addr == 0 && !ide_dd_oe, {"R8 idle at done ", tag},
            {ide_cs, ide_addr, ide_dd_oe}, 0);
        @(negedge clk);
        chk(!done, {"R5 done one cycle ", tag}, done, 0);
    endtask

    // R11: start while in powerdown
    task automatic t_pdn_start();
        bit strb = 0;
        write_cfg(mk_cfg(1, 0, 0, 2, 2, 2));
        @(negedge clk);
        start = 1'b1; is_write = 1'b0; reg_sel = 5'h0A;
        @(negedge clk);
        start = 1'b0;
        chk(done, "R11 immediate done", done, 1);
        chk(rd_data == 0, "R11 zero read", rd_data, 0);
        for (int k = 0; k < 6; k++) begin
            if (ide_rd_strb || ide_wr_strb) strb = 1;
            @(negedge clk);
        end
        chk(!strb, "R11 no strobe", strb, 0);
        chk(!ide_rst_n && card_pwr && ide_cs == 0, "R9 powerdown forced", {ide_rst_n, card_pwr}, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_readback();
        t_static();
        run_access(0, 5'b01_110, 16'h0000, 3, 7, 19, 0, "mode0 read");
        run_access(1, 5'b10_010, 16'hC0DE, 1, 2, 0, 0, "mode4 write");
        run_access(0, 5'b01_000, 16'h0000, 0, 0, 0, 0, "min read");
        run_access(1, 5'b01_111, 16'h5A5A, 7, 31, 31, 0, "max write");
        run_access(0, 5'b01_101, 16'h0000, 1, 2, 0, 1, "R12 snapshot");
        t_pdn_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule